// File: doc/BRIEF.md
# Hysteretic Valley Mode Selector

This block chooses the operating mode of a quasi-resonant flyback controller from a digitized feedback level. Each time a valid sample arrives, it compares the sample with a ladder of thresholds. It then picks one of five ordered modes: switching in the first, second, third or fourth valley, or a variable-frequency oscillator mode for the lightest loads. Every boundary in the ladder has a lower threshold for falling feedback and a higher one for rising feedback. Once a valley is chosen, small feedback ripple cannot make the selection chatter between neighbours.

The sample is an unsigned millivolt code qualified by a valid strobe. The block produces a 3-bit mode code, a one-cycle change pulse, a flag that marks the peak-current setpoint as frozen, and the peak-current setpoint itself in millivolts. In valley modes the setpoint follows the feedback divided by four. In oscillator mode the setpoint follows feedback down to a floor of 17.5 % of its maximum and then holds at that floor.

Top module: `valley_mode_sel`

## Requirements
- R1: After reset the mode code is 0 (first valley), the change pulse and the freeze flag are low, and the setpoint equals the maximum, 800 mV.
- R2: A valid sample strictly below the falling threshold of the current mode moves the mode one step lighter. The falling thresholds are 1400 mV (code 0 to 1), 1200 mV (1 to 2), 900 mV (2 to 3) and 800 mV (3 to 4).
- R3: A valid sample strictly above the rising threshold of the current mode moves the mode one step heavier. The rising thresholds are 2000 mV (code 1 to 0), 1800 mV (2 to 1), 1600 mV (3 to 2) and 1400 mV (4 to 3).
- R4: A valid sample that lies between the two thresholds of the current mode, or exactly on one of them, leaves the mode unchanged.
- R5: One valid sample changes the mode code by at most one step, so a large jump in feedback walks the ladder one step per sample.
- R6: While the valid strobe is low, the mode code, the setpoint and the freeze flag hold their values and the change pulse is low.
- R7: The change pulse is high for exactly the one cycle in which a new mode code first appears. It is low otherwise.
- R8: In mode codes 0 to 3 the setpoint after a valid sample equals the sample divided by four (truncated), clamped to at most 800 mV. The freeze flag is low.
- R9: In mode code 4 the setpoint after a valid sample equals the larger of the sample divided by four and 140 mV. The freeze flag is high.
- R10: The mode code never exceeds 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control tick clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fb_vld_i | input | 1 | Feedback sample valid strobe |
| fb_mv_i | input | 12 | Feedback sample, unsigned millivolts |
| mode_o | output | 3 | Mode code: 0..3 valleys 1..4, 4 oscillator mode |
| mode_chg_o | output | 1 | One-cycle pulse on every mode change |
| sp_freeze_o | output | 1 | Setpoint frozen (oscillator mode) |
| ipk_sp_o | output | 10 | Peak-current setpoint, millivolts |

## Verification
The embedded properties check on every cycle that the mode code stays legal, moves at most one step per sample and holds while no sample arrives. They also check that the change pulse appears only when the code actually changes, and that the setpoint stays inside the bounds of its current mode. Only the bench scenarios can show that each transition happens at the exact threshold, strictly and with the right direction. The same applies to samples exactly on a threshold, which must cause no move, and to the exact setpoint values: the divide-by-four, the 800 mV clamp and the 140 mV floor.

// File: rtl/vms_pkg.sv
package vms_pkg;
    localparam int MODE_W = 3;
    localparam int NUM_MODES = 5;

    typedef enum logic [MODE_W-1:0] {
        MD_V1  = 3'd0,
        MD_V2  = 3'd1,
        MD_V3  = 3'd2,
        MD_V4  = 3'd3,
        MD_OSC = 3'd4
    } mode_e;
endpackage

// File: rtl/vms_step.sv
module vms_step
    import vms_pkg::*;
#(
    parameter int FB_W   = 12,
    parameter int DN_01  = 1400,
    parameter int DN_12  = 1200,
    parameter int DN_23  = 900,
    parameter int DN_34  = 800,
    parameter int UP_10  = 2000,
    parameter int UP_21  = 1800,
    parameter int UP_32  = 1600,
    parameter int UP_43  = 1400
) (
    input  mode_e           cur_i,
    input  logic [FB_W-1:0] fb_i,
    output mode_e           nxt_o
);
    localparam int NB = NUM_MODES - 1;
    localparam int DN_TAB [NB] = '{DN_01, DN_12, DN_23, DN_34};
    localparam int UP_TAB [NB] = '{UP_10, UP_21, UP_32, UP_43};

    logic [NB-1:0] go_dn;
    logic [NB-1:0] go_up;

    // Boundary k separates mode k (heavier) from mode k+1 (lighter).
    for (genvar k = 0; k < NB; k++) begin : g_bnd
        assign go_dn[k] = (cur_i == mode_e'(k))
                        && (int'(fb_i) < DN_TAB[k]);
        assign go_up[k] = (cur_i == mode_e'(k + 1))
                        && (int'(fb_i) > UP_TAB[k]);
    end

    always_comb begin
        nxt_o = cur_i;
        if (|go_dn) begin
            nxt_o = mode_e'(cur_i + 3'd1);
        end else if (|go_up) begin
            nxt_o = mode_e'(cur_i - 3'd1);
        end
    end
endmodule

// File: rtl/vms_setpoint.sv
module vms_setpoint
    import vms_pkg::*;
#(
    parameter int FB_W    = 12,
    parameter int SP_W    = 10,
    parameter int IPK_MAX = 800,
    parameter int FLR_PM  = 175
) (
    input  mode_e           mode_i,
    input  logic [FB_W-1:0] fb_i,
    output logic [SP_W-1:0] sp_o,
    output logic            frz_o
);
    localparam int FLOOR = (IPK_MAX * FLR_PM) / 1000;
    localparam logic [SP_W-1:0] MAX_C = SP_W'(IPK_MAX);
    localparam logic [SP_W-1:0] FLR_C = SP_W'(FLOOR);

    logic [SP_W-1:0] quarter;

    assign quarter = fb_i[FB_W-1:2];

    always_comb begin
        frz_o = (mode_i == MD_OSC);
        if (frz_o) begin
            sp_o = (quarter < FLR_C) ? FLR_C : quarter;
        end else begin
            sp_o = (quarter > MAX_C) ? MAX_C : quarter;
        end
    end
endmodule

// File: rtl/valley_mode_sel.sv
module valley_mode_sel
    import vms_pkg::*;
#(
    parameter int FB_W    = 12,
    parameter int IPK_MAX = 800,
    parameter int FLR_PM  = 175
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fb_vld_i,
    input  logic [FB_W-1:0]   fb_mv_i,
    output logic [2:0]        mode_o,
    output logic              mode_chg_o,
    output logic              sp_freeze_o,
    output logic [FB_W-3:0]   ipk_sp_o
);
    localparam int SP_W  = FB_W - 2;
    localparam int FLOOR = (IPK_MAX * FLR_PM) / 1000;

    typedef struct packed {
        mode_e           mode;
        logic            chg;
        logic            frz;
        logic [SP_W-1:0] sp;
    } state_t;

    state_t s_d, s_q;
    mode_e  step_nxt;
    logic [SP_W-1:0] sp_nxt;
    logic   frz_nxt;

    vms_step #(.FB_W(FB_W)) u_step (
        .cur_i (s_q.mode),
        .fb_i  (fb_mv_i),
        .nxt_o (step_nxt)
    );

    vms_setpoint #(
        .FB_W(FB_W), .SP_W(SP_W), .IPK_MAX(IPK_MAX), .FLR_PM(FLR_PM)
    ) u_sp (
        .mode_i (step_nxt),
        .fb_i   (fb_mv_i),
        .sp_o   (sp_nxt),
        .frz_o  (frz_nxt)
    );

    always_comb begin
        s_d     = s_q;
        s_d.chg = 1'b0;
        if (fb_vld_i) begin
            s_d.mode = step_nxt;
            s_d.chg  = (step_nxt != s_q.mode);
            s_d.frz  = frz_nxt;
            s_d.sp   = sp_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.mode <= MD_V1;
            s_q.chg  <= 1'b0;
            s_q.frz  <= 1'b0;
            s_q.sp   <= SP_W'(IPK_MAX);
        end else begin
            s_q <= s_d;
        end
    end

    assign mode_o      = s_q.mode;
    assign mode_chg_o  = s_q.chg;
    assign sp_freeze_o = s_q.frz;
    assign ipk_sp_o    = s_q.sp;

    // R10
    mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o <= 3'd4);

    // R5
    one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fb_vld_i |=> ((mode_o == $past(mode_o)) ||
                      (mode_o == $past(mode_o) + 3'd1) ||
                      (mode_o + 3'd1 == $past(mode_o))));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fb_vld_i |=> ($stable(mode_o) && $stable(ipk_sp_o) && !mode_chg_o));

    // R7
    chg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg_o |-> (mode_o != $past(mode_o)));

    // R9
    osc_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sp_freeze_o |-> (int'(ipk_sp_o) >= FLOOR));

    // R8
    valley_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sp_freeze_o |-> (int'(ipk_sp_o) <= IPK_MAX));
endmodule

// File: tb/valley_mode_sel_tb_top.sv
module valley_mode_sel_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fb_vld_i = 1'b0;
    logic [11:0] fb_mv_i = '0;
    logic [2:0]  mode_o;
    logic        mode_chg_o;
    logic        sp_freeze_o;
    logic [9:0]  ipk_sp_o;

    int n_cmp = 0;
    int n_bad = 0;
    int exp_mode = 0;

    typedef struct {
        int    mode;
        bit    chg;
        bit    frz;
        int    sp;
        string tag;
    } item_t;

    item_t sb_q[$];

    always #2.5 clk = ~clk;

    valley_mode_sel dut_i (
        .clk(clk), .rst_n(rst_n), .fb_vld_i(fb_vld_i), .fb_mv_i(fb_mv_i),
        .mode_o(mode_o), .mode_chg_o(mode_chg_o),
        .sp_freeze_o(sp_freeze_o), .ipk_sp_o(ipk_sp_o)
    );

    function automatic int model_next(int m, int fb);
        case (m)
            0: return (fb < 1400) ? 1 : 0;
            1: return (fb < 1200) ? 2 : (fb > 2000) ? 0 : 1;
            2: return (fb < 900)  ? 3 : (fb > 1800) ? 1 : 2;
            3: return (fb < 800)  ? 4 : (fb > 1600) ? 2 : 3;
            default: return (fb > 1400) ? 3 : 4;
        endcase
    endfunction

    task automatic check(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic drive(int fb, string tag);
        item_t it;
        int nm = model_next(exp_mode, fb);
        it.chg  = (nm != exp_mode);
        it.mode = nm;
        it.frz  = (nm == 4);
        if (nm == 4) it.sp = (fb / 4 < 140) ? 140 : fb / 4;
        else         it.sp = (fb / 4 > 800) ? 800 : fb / 4;
        it.tag  = tag;
        exp_mode = nm;
        sb_q.push_back(it);
        @(negedge clk);
        fb_mv_i  = 12'(fb);
        fb_vld_i = 1'b1;
        @(negedge clk);
        fb_vld_i = 1'b0;
        fb_mv_i  = 12'hABC;
    endtask

    // Monitor: compare one item per accepted sample; idle cycles must keep outputs.
    initial begin
        item_t it;
        int last_mode = 0;
        int last_sp = 800;
        forever begin
            @(posedge clk);
            if (rst_n) begin
                if (fb_vld_i) begin
                    @(negedge clk);
                    if (sb_q.size() == 0) begin
                        check("R2 scoreboard empty", 1, 0);
                    end else begin
                        it = sb_q.pop_front();
                        check({it.tag, " mode"}, int'(mode_o), it.mode);
                        check({it.tag, " R7 chg"}, int'(mode_chg_o), int'(it.chg));
                        check({it.tag, " R9 frz"}, int'(sp_freeze_o), int'(it.frz));
                        check({it.tag, " R8/R9 sp"}, int'(ipk_sp_o), it.sp);
                        last_mode = it.mode;
                        last_sp = it.sp;
                    end
                end else begin
                    @(negedge clk);
                    check("R6 idle mode", int'(mode_o), last_mode);
                    check("R6 idle sp", int'(ipk_sp_o), last_sp);
                    check("R6 idle chg", int'(mode_chg_o), 0);
                end
            end
        end
    end

    initial begin
        int cyc = 0;
        while (cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        check("watchdog expired", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 mode", int'(mode_o), 0);
        check("R1 chg", int'(mode_chg_o), 0);
        check("R1 frz", int'(sp_freeze_o), 0);
        check("R1 sp", int'(ipk_sp_o), 800);
        rst_n = 1'b1;
        @(negedge clk);
        drive(2500, "R8 full load");
        drive(1400, "R4 on falling threshold");
        drive(1399, "R2 v1 to v2");
        drive(1300, "R4 v2 band");
        drive(2000, "R4 on rising threshold");
        drive(1199, "R2 v2 to v3");
        drive(850,  "R2 v3 to v4");
        drive(850,  "R4 v4 band");
        drive(799,  "R2 v4 to osc");
        drive(400,  "R9 floor hold");
        drive(1400, "R4 osc at rising threshold");
        drive(1401, "R3 osc to v4");
        drive(3000, "R5 walk up 1");
        drive(3000, "R5 walk up 2");
        drive(3000, "R5 walk up 3");
        drive(4095, "R8 clamp");
        drive(100,  "R5 walk down 1");
        drive(100,  "R5 walk down 2");
        drive(100,  "R5 walk down 3");
        drive(100,  "R5 walk down 4");
        drive(100,  "R10 stay at osc");
        drive(1700, "R3 osc to v4 mid");
        drive(1700, "R3 v4 to v3");
        drive(1801, "R3 v3 to v2");
        repeat (3) @(negedge clk);
        check("R2 scoreboard drained", sb_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule